// File: doc/BRIEF.md
# Interrupt Pin Delivery and EOI Engine

This block sits between a set of interrupt input pins and a message channel toward interrupt receivers. Each pin is driven by one-cycle assert and deassert strobes, and the pin's redirection entry arrives as plain configuration inputs from the register window: the vector, the destination, a mask bit and the trigger mode. From these the block keeps a pending bit and a service request per pin. It sends one message at a time (pin, vector, destination, trigger mode) over a valid/ready handshake, and it picks the lowest-numbered eligible pin first.

Level-triggered pins are gated by a remote-IRR bit. The bit is set when the message is accepted and is handed back to the register window. An end-of-interrupt (EOI) strobe carrying a vector clears remote IRR on every level pin whose entry uses that vector, and it redelivers any such pin that is still pending and unmasked. Each pin counts the EOI-driven redeliveries that follow one another. When a pin reaches a parameterised limit, the block stops redelivering it at once and starts a single shared deferral timer. When that timer runs out, every pending level pin with remote IRR clear is serviced. This slows a storm from an interrupt source that is never quietened, but the source still makes progress.

Top module: `intr_deliver_eoi`

## Requirements
- R1: A deassert strobe clears the pin's pending bit and withdraws its request. A pin deasserted before delivery produces no message, even after it is unmasked later.
- R2: On an edge pin (entry trigger bit 0), an assert strobe that arrives while the pending bit is already set is coalesced and produces no message. After a deassert, the next assert delivers again.
- R3: A masked pin (mask bit 1), or a level pin whose remote IRR is set, is not delivered. Its request stays pending. A request held back by the mask is delivered once the mask clears.
- R4: When the receiver accepts a message for a level pin (entry trigger bit 1), that pin's bit in `rirr_out` (bit i for pin i) becomes 1. Edge pins never set remote IRR.
- R5: An EOI clears remote IRR on every level pin whose entry vector equals the EOI vector. Each such pin that is still pending and unmasked is delivered again. An EOI has no effect on edge pins.
- R6: Each level pin counts successive EOI-driven redeliveries. The EOI that brings the count to STORM_LIMIT does not redeliver. It resets the count to 0 and starts the deferral timer.
- R7: An EOI that finds a matching level pin masked or no longer pending resets that pin's count to 0.
- R8: When a level entry's mask changes from 1 to 0 while its pending bit is set and remote IRR is clear, the pin is delivered.
- R9: DEFER_CYCLES cycles after the deferral timer starts, every level pin that is pending with remote IRR clear is requested again.
- R10: When several pins are eligible, the lowest-numbered pin is loaded first.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and the message fields do not change.
- R12: After reset, no message is offered and all remote-IRR bits are 0.
- R13: If another pin reaches the limit while a deferral is running, the deferral is not restarted. The pending pins are serviced at the original expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_assert | input | NPINS | One-cycle assert strobe per pin |
| irq_deassert | input | NPINS | One-cycle deassert strobe per pin (wins over assert) |
| ent_mask | input | NPINS | Entry mask bit per pin, 1 = masked |
| ent_level | input | NPINS | Entry trigger bit per pin, 1 = level, 0 = edge |
| ent_vector | input | NPINS*VEC_W | Entry vector per pin, pin i at bits [i*VEC_W +: VEC_W] |
| ent_dest | input | NPINS*DEST_W | Entry destination per pin, pin i at bits [i*DEST_W +: DEST_W] |
| rirr_out | output | NPINS | Remote-IRR bit per pin, returned to the register window |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_pin | output | $clog2(NPINS) | Source pin of the message |
| msg_vector | output | VEC_W | Vector of the message |
| msg_dest | output | DEST_W | Destination of the message |
| msg_level | output | 1 | Trigger mode of the message, 1 = level |

## Verification
On every cycle, the embedded properties check these points:
- A held message keeps its fields.
- An accepted level message leaves remote IRR set.
- A matching EOI leaves it clear.
- A deassert leaves the pin ineligible.
- Each grant is the lowest requester.
- The redelivery count stays below its limit.
- A running deferral only counts forward when another pin hits the threshold.

Other behaviours span many cycles, and only the bench scenarios show them: coalescing of repeated edges, the exact EOI on which a storm is deferred, the counter reset by a masked EOI, the moment the deferred pins return, and the order of several pins that wait at the same time.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/intr_pin_ctrl.sv
module intr_pin_ctrl
  import intr_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             assert_i,
  input  logic             deassert_i,
  input  logic             mask_i,
  input  logic             level_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic             eoi_valid_i,
  input  logic [VEC_W-1:0] eoi_vector_i,
  input  logic             expire_i,
  input  logic             load_i,
  input  logic             accept_i,
  output logic             elig_o,
  output logic             rirr_o,
  output logic             defer_o
);
  localparam int CW = $clog2(STORM_LIMIT + 1);

  logic          pend, want, rirr, mask_q;
  logic [CW-1:0] cnt;
  logic          pend_n, want_n, rirr_n;
  logic [CW-1:0] cnt_n, cnt_inc;
  logic          eoi_hit, redo, storm, unmask_ev, rirr_after;
  trig_e         trig;

  always_comb begin
    trig       = level_i ? TRIG_LEVEL : TRIG_EDGE;
    eoi_hit    = eoi_valid_i && (eoi_vector_i == vector_i) && (trig == TRIG_LEVEL);
    redo       = eoi_hit && pend && !mask_i;
    cnt_inc    = cnt + 1'b1;
    storm      = redo && (cnt_inc == CW'(STORM_LIMIT));
    rirr_after = rirr && !eoi_hit;
    unmask_ev  = mask_q && !mask_i && (trig == TRIG_LEVEL) && pend && !rirr;
  end

  always_comb begin
    want_n = want;
    if (redo) want_n = !storm;
    if (expire_i && (trig == TRIG_LEVEL) && pend && !rirr_after) want_n = 1'b1;
    if (unmask_ev) want_n = 1'b1;
    if (load_i) want_n = 1'b0;
    if (assert_i && ((trig == TRIG_LEVEL) || !pend)) want_n = 1'b1;
    if (deassert_i) want_n = 1'b0;

    pend_n = pend;
    if (assert_i) pend_n = 1'b1;
    if (deassert_i) pend_n = 1'b0;

    rirr_n = rirr_after;
    if (accept_i) rirr_n = 1'b1;
    if (trig == TRIG_EDGE) rirr_n = 1'b0;

    cnt_n = cnt;
    if (eoi_hit) cnt_n = (redo && !storm) ? cnt_inc : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      want   <= 1'b0;
      rirr   <= 1'b0;
      mask_q <= 1'b1;
      cnt    <= '0;
    end else begin
      pend   <= pend_n;
      want   <= want_n;
      rirr   <= rirr_n;
      mask_q <= mask_i;
      cnt    <= cnt_n;
    end
  end

  assign elig_o  = want && pend && !mask_i && !((trig == TRIG_LEVEL) && rirr);
  assign rirr_o  = rirr;
  assign defer_o = storm;

  assert_rirr_on_accept_R4: assert property (@(posedge clk) disable iff (rst)
    accept_i && level_i |=> rirr_o);
  assert_eoi_clears_rirr_R5: assert property (@(posedge clk) disable iff (rst)
    eoi_hit && !accept_i |=> !rirr_o);
  assert_deassert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    deassert_i |=> !elig_o);
  assert_storm_holds_R6: assert property (@(posedge clk) disable iff (rst)
    storm && !expire_i && !assert_i && !unmask_ev |=> !elig_o);
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(STORM_LIMIT));
endmodule

// File: rtl/intr_lowest_pick.sv
module intr_lowest_pick #(
  parameter int N = 8,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [PW-1:0] idx
);
  assign gnt = req & (~req + N'(1));
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (gnt[i]) idx = PW'(i);
    end
  end

  assert_grant_lowest_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0) && (((gnt - N'(1)) & req & {N{any}}) == '0));
endmodule

// File: rtl/intr_defer_timer.sv
module intr_defer_timer #(
  parameter int DELAY = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic expire_o
);
  localparam int TW = (DELAY > 2) ? $clog2(DELAY) : 1;

  logic          run;
  logic [TW-1:0] cnt;

  assign expire_o = run && (cnt == TW'(DELAY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      if (expire_o) begin
        run <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start_i) begin
      run <= 1'b1;
      cnt <= '0;
    end
  end

  assert_no_restart_R13: assert property (@(posedge clk) disable iff (rst)
    run && start_i && !expire_o |=> run && (cnt == $past(cnt) + 1'b1));
  assert_expiry_stops_R9: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !run);
endmodule

// File: rtl/intr_deliver_eoi.sv
module intr_deliver_eoi #(
  parameter int NPINS        = 8,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 64,
  localparam int PW = $clog2(NPINS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPINS-1:0]        irq_assert,
  input  logic [NPINS-1:0]        irq_deassert,
  input  logic [NPINS-1:0]        ent_mask,
  input  logic [NPINS-1:0]        ent_level,
  input  logic [NPINS*VEC_W-1:0]  ent_vector,
  input  logic [NPINS*DEST_W-1:0] ent_dest,
  output logic [NPINS-1:0]        rirr_out,
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vector,
  output logic                    msg_valid,
  input  logic                    msg_ready,
  output logic [PW-1:0]           msg_pin,
  output logic [VEC_W-1:0]        msg_vector,
  output logic [DEST_W-1:0]       msg_dest,
  output logic                    msg_level
);
  logic [NPINS-1:0] elig, gnt, load_pin, acc_pin, storm_hit;
  logic             any, expire, slot_free, accept;
  logic [PW-1:0]    pick;

  assign accept    = msg_valid && msg_ready;
  assign slot_free = !msg_valid || msg_ready;
  assign load_pin  = gnt & {NPINS{slot_free}};

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign acc_pin[i] = accept && msg_level && (msg_pin == PW'(i));
    intr_pin_ctrl #(.VEC_W(VEC_W), .STORM_LIMIT(STORM_LIMIT)) u_pin (
      .clk(clk), .rst(rst),
      .assert_i(irq_assert[i]), .deassert_i(irq_deassert[i]),
      .mask_i(ent_mask[i]), .level_i(ent_level[i]),
      .vector_i(ent_vector[i*VEC_W +: VEC_W]),
      .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vector),
      .expire_i(expire), .load_i(load_pin[i]), .accept_i(acc_pin[i]),
      .elig_o(elig[i]), .rirr_o(rirr_out[i]), .defer_o(storm_hit[i])
    );
  end

  intr_lowest_pick #(.N(NPINS)) u_pick (
    .clk(clk), .rst(rst), .req(elig), .gnt(gnt), .any(any), .idx(pick)
  );

  intr_defer_timer #(.DELAY(DEFER_CYCLES)) u_defer (
    .clk(clk), .rst(rst), .start_i(|storm_hit), .expire_o(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_pin    <= '0;
      msg_vector <= '0;
      msg_dest   <= '0;
      msg_level  <= 1'b0;
    end else if (slot_free) begin
      msg_valid <= any;
      if (any) begin
        msg_pin    <= pick;
        msg_vector <= ent_vector[pick*VEC_W +: VEC_W];
        msg_dest   <= ent_dest[pick*DEST_W +: DEST_W];
        msg_level  <= ent_level[pick];
      end
    end
  end

  assert_hold_msg_R11: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_pin) && $stable(msg_vector)
      && $stable(msg_dest) && $stable(msg_level));
endmodule

// File: tb/intr_deliver_eoi_test.sv
module intr_deliver_eoi_test;
  localparam int NP = 8;
  localparam int VW = 8;
  localparam int DW = 8;
  localparam int LIMIT = 4;
  localparam int DEFER = 16;
  localparam int PW = $clog2(NP);

  localparam logic [3:0] OP_AS = 4'h1, OP_DE = 4'h2, OP_MK = 4'h3, OP_LV = 4'h4,
                         OP_EOI = 4'h5, OP_MSG = 4'h6, OP_NONE = 4'h7, OP_RIRR = 4'h8;
  // word = {requirement, op, pin, value}
  localparam int NSTEPS = 62;
  localparam logic [19:0] STEPS [NSTEPS] = '{
    20'hC7004, 20'hC8000,                                   // R12 idle after reset
    20'h33100, 20'h31100, 20'h36100,                        // R3 edge pin 1 delivered
    20'h27004, 20'h21100, 20'h27004,                        // R2 coalesced assert
    20'h22100, 20'h21100, 20'h26100,                        // R2 new edge after deassert
    20'h31400, 20'h37004, 20'h33400, 20'h36400,             // R3 held by mask
    20'h11500, 20'h12500, 20'h13500, 20'h17006,             // R1 deassert withdraws
    20'h44001, 20'h43000, 20'h41000, 20'h46000, 20'h48001,  // R4 level sets remote IRR
    20'h31000, 20'h37004,                                   // R3 blocked by remote IRR
    20'h55020, 20'h56000, 20'h58001,                        // R5 EOI redelivers
    20'h52000, 20'h55020, 20'h57004, 20'h58000,             // R5 EOI, no longer pending
    20'hA4201, 20'hA4301, 20'hA3200, 20'hA3300, 20'hA3700,  // R10 setup
    20'hA1700, 20'hA1300, 20'hA1200,                        // R10 queue behind held message
    20'hA6700, 20'hA6200, 20'hA6300, 20'h4800C,             // R10 order, R4 two bits
    20'h55040, 20'h56200, 20'h56300,                        // R5 shared vector
    20'h52200, 20'h52300, 20'h55040, 20'h58000,             // R5 clear both
    20'h84601, 20'h81600, 20'h87004, 20'h83600, 20'h86600,  // R8 unmask service
    20'h33601, 20'h33600, 20'h37004,                        // R3 unmask with remote IRR set
    20'h55021, 20'h57004                                    // R5 EOI ignored by edge pin
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] a_pulse = '0, d_pulse = '0, mask_r = '1, level_r = '0;
  logic [NP*VW-1:0] vec_flat;
  logic [NP*DW-1:0] dest_flat;
  logic [NP-1:0] rirr_out;
  logic eoi_v = 1'b0;
  logic [VW-1:0] eoi_vec = '0;
  logic msg_valid, msg_ready = 1'b0, msg_level;
  logic [PW-1:0] msg_pin;
  logic [VW-1:0] msg_vector;
  logic [DW-1:0] msg_dest;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  function automatic logic [VW-1:0] vec_of(input int p);
    return (p == 2 || p == 3) ? 8'h40 : 8'h20 + VW'(p);
  endfunction

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      vec_flat[p*VW +: VW]  = vec_of(p);
      dest_flat[p*DW +: DW] = DW'(p * 3 + 1);
    end
  end

  intr_deliver_eoi #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW), .STORM_LIMIT(LIMIT),
                     .DEFER_CYCLES(DEFER)) uut (
    .clk(clk), .rst(rst), .irq_assert(a_pulse), .irq_deassert(d_pulse),
    .ent_mask(mask_r), .ent_level(level_r), .ent_vector(vec_flat), .ent_dest(dest_flat),
    .rirr_out(rirr_out), .eoi_valid(eoi_v), .eoi_vector(eoi_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_level(msg_level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit up, input int p);
    @(negedge clk);
    if (up) a_pulse[p] = 1'b1; else d_pulse[p] = 1'b1;
    @(negedge clk);
    a_pulse = '0;
    d_pulse = '0;
  endtask

  task automatic send_eoi(input logic [VW-1:0] v);
    @(negedge clk);
    eoi_v = 1'b1;
    eoi_vec = v;
    @(negedge clk);
    eoi_v = 1'b0;
  endtask

  task automatic set_mask(input int p, input bit v);
    @(negedge clk);
    mask_r[p] = v;
  endtask

  task automatic expect_msg(input int p, input string req);
    bit ok;
    for (int k = 0; k < 8 && !msg_valid; k++) @(negedge clk);
    ok = msg_valid && msg_pin == PW'(p) && msg_vector == vec_of(p)
         && msg_dest == DW'(p * 3 + 1) && msg_level == level_r[p];
    check(ok, req, msg_valid ? int'(msg_pin) : -1, p);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_none(input int n, input string req);
    bit seen = 1'b0;
    int who = -1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid && !seen) begin seen = 1'b1; who = int'(msg_pin); end
    end
    check(!seen, req, who, -1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    mask_r = '1;
    level_r = '0;
    a_pulse = '0;
    d_pulse = '0;
    eoi_v = 1'b0;
    msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [19:0] w;
    string tag;
    int waited;
    logic [PW-1:0] p0;
    logic [VW-1:0] v0;
    bit stable;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int s = 0; s < NSTEPS; s++) begin
      w = STEPS[s];
      tag = $sformatf("R%0d step %0d", w[19:16], s);
      case (w[15:12])
        OP_AS:   pulse(1'b1, int'(w[11:8]));
        OP_DE:   pulse(1'b0, int'(w[11:8]));
        OP_MK:   set_mask(int'(w[11:8]), w[0]);
        OP_LV:   begin @(negedge clk); level_r[w[11:8]] = w[0]; end
        OP_EOI:  send_eoi(w[7:0]);
        OP_MSG:  expect_msg(int'(w[11:8]), tag);
        OP_NONE: expect_none(int'(w[7:0]), tag);
        OP_RIRR: begin
          @(negedge clk);
          check(rirr_out == w[NP-1:0], tag, int'(rirr_out), int'(w[NP-1:0]));
        end
        default: ;
      endcase
    end

    // R12: reset clears the remote IRR left on pin 6 and offers nothing
    do_reset();
    check(!msg_valid && rirr_out == '0, "R12 reset", int'(rirr_out), 0);

    // R11: held message under back-pressure
    set_mask(5, 1'b0);
    pulse(1'b1, 5);
    @(negedge clk);
    p0 = msg_pin;
    v0 = msg_vector;
    stable = msg_valid;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!msg_valid || msg_pin != p0 || msg_vector != v0) stable = 1'b0;
    end
    check(stable && p0 == PW'(5), "R11 hold", int'(p0), 5);
    expect_msg(5, "R11 accept");

    // R6 / R7 / R8: storm counting on level pin 0
    @(negedge clk);
    level_r[0] = 1'b1;
    set_mask(0, 1'b0);
    pulse(1'b1, 0);
    expect_msg(0, "R4 first");
    for (int k = 0; k < LIMIT - 1; k++) begin
      send_eoi(8'h20);
      expect_msg(0, "R6 redeliver below limit");
    end
    set_mask(0, 1'b1);
    send_eoi(8'h20);
    expect_none(4, "R7 masked EOI");
    set_mask(0, 1'b0);
    expect_msg(0, "R8 unmask after masked EOI");
    for (int k = 0; k < LIMIT - 1; k++) begin
      send_eoi(8'h20);
      expect_msg(0, "R7 count restarted");
    end

    // pin 6 built up to LIMIT-1 redeliveries
    @(negedge clk);
    level_r[6] = 1'b1;
    set_mask(6, 1'b0);
    pulse(1'b1, 6);
    expect_msg(6, "R4 pin 6");
    for (int k = 0; k < LIMIT - 1; k++) begin
      send_eoi(8'h26);
      expect_msg(6, "R6 pin 6 redeliver");
    end

    // R6: limit reached on pin 0, deferral starts
    send_eoi(8'h20);
    waited = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      waited++;
      if (msg_valid) break;
    end
    check(!msg_valid, "R6 deferred", int'(msg_valid), 0);
    // R13: pin 6 hits the limit during the running deferral
    send_eoi(8'h26);
    waited += 2;
    while (!msg_valid && waited < DEFER + 8) begin
      @(negedge clk);
      waited++;
    end
    check(msg_valid && waited >= DEFER - 1 && waited <= DEFER + 3,
          "R13 original expiry", waited, DEFER + 1);
    expect_msg(0, "R9 pin 0 after expiry");
    expect_msg(6, "R9 pin 6 after expiry");
    send_eoi(8'h20);
    expect_msg(0, "R6 count cleared after deferral");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule